// File: doc/BRIEF.md
# Predicated Vector Lane Execution Unit

This block is a multi-lane vector execution unit in which every vector write is gated, lane by lane, by a mask taken from a small predicate register file. It holds the vector registers and the predicate registers. It accepts one instruction per cycle. An instruction is an opcode, vector register indices, a predicate destination, a predicate source, a predication enable and an invert bit.

A signed lane-wise less-than compare fills a predicate register. Moves, adds, subtracts and immediate loads then write only the lanes that the chosen predicate, or its complement, selects. A population count reduces a predicate, or its complement, to a registered scalar with a zero flag. Control logic uses that flag to skip a path in which no lane is active. Read ports expose one vector register and one predicate register at a time.

Top module: `pred_vec_unit`

## Requirements
- R1: Opcode 1 (compare) writes predicate register `pd_i` whole, with no predication: bit i becomes 1 exactly when lane i of register `va_i` is less than lane i of register `vb_i`, both read as signed two's-complement. Lane i occupies bits [32i+31:32i] of every vector bus and bit i of every predicate bus.
- R2: With `pen_i`=1 and `pinv_i`=0, a vector-writing opcode updates lane i of register `vd_i` only where bit i of predicate `ps_i` is 1. Every other lane keeps its old value.
- R3: With `pen_i`=1 and `pinv_i`=1, a vector-writing opcode updates only the lanes whose bit in predicate `ps_i` is 0.
- R4: Opcode 6 (count) places the number of set bits of predicate `ps_i`, or of its complement when `pinv_i`=1, on `scal_o`. `scal_valid_o` is high for exactly the cycle after the instruction is accepted.
- R5: `zero_o` is 1 alongside a count result when that count is 0. This holds both for an all-zero predicate counted plain and for an all-one predicate counted inverted.
- R6: With `pen_i`=0, a vector-writing opcode updates all lanes, whatever `ps_i` and `pinv_i` are.
- R7: The vector-writing opcodes are 2 (copy `va_i`), 3 (`va_i`+`vb_i` modulo 2^32), 4 (`va_i`-`vb_i` modulo 2^32) and 5 (lane i of `imm_i`). The result lands in `vd_i`, and `vd_i` may equal a source.
- R8: After reset, every vector register and predicate register reads 0, `scal_valid_o` is 0 and `scal_o` is 0.
- R9: Opcodes 0 and 7, or any cycle with `valid_i` low, change no vector register and no predicate register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| op_i | input | 3 | Opcode |
| vd_i | input | 3 | Vector destination index |
| va_i | input | 3 | First vector source index |
| vb_i | input | 3 | Second vector source index |
| pd_i | input | 2 | Predicate destination index for compare |
| ps_i | input | 2 | Predicate source index for masking and count |
| pen_i | input | 1 | Predication enable |
| pinv_i | input | 1 | Use the complement of the source predicate |
| imm_i | input | 256 | Per-lane immediate data for opcode 5 |
| rd_vidx_i | input | 3 | Vector read port index |
| rd_pidx_i | input | 2 | Predicate read port index |
| rd_vdata_o | output | 256 | Contents of vector register `rd_vidx_i` |
| rd_pdata_o | output | 8 | Contents of predicate register `rd_pidx_i` |
| scal_o | output | 4 | Last count result |
| scal_valid_o | output | 1 | Count result valid |
| zero_o | output | 1 | Last count result was zero |

## Verification
The bench builds the unit with its default parameters: 8 lanes of 32 bits, 8 vector registers and 4 predicate registers.

With so few registers, randomly drawn indices often coincide. This produces destination-equals-source writes, and it makes instructions reuse predicates that the compare just before them wrote. The lane values include the signed extremes and small values of both signs, so compares see equal lanes and values that differ in sign.

Directed sequences build all-one and all-zero predicates. These exercise the count in both polarities and the zero flag.

// File: rtl/pvu_pkg.sv
package pvu_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_CMPLT = 3'd1,
    OP_MOV   = 3'd2,
    OP_ADD   = 3'd3,
    OP_SUB   = 3'd4,
    OP_LDI   = 3'd5,
    OP_POPC  = 3'd6,
    OP_RSV   = 3'd7
  } pvu_op_e;
endpackage

// File: rtl/pvu_lane.sv
module pvu_lane
  import pvu_pkg::*;
#(
  parameter int ELEM_W   = 32,
  parameter int NUM_VREG = 8,
  localparam int VIDX_W  = $clog2(NUM_VREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  pvu_op_e           op_i,
  input  logic [VIDX_W-1:0] vd_i,
  input  logic [VIDX_W-1:0] va_i,
  input  logic [VIDX_W-1:0] vb_i,
  input  logic [ELEM_W-1:0] imm_i,
  input  logic [VIDX_W-1:0] rd_idx_i,
  output logic              lt_o,
  output logic [ELEM_W-1:0] rd_data_o
);
  logic [NUM_VREG-1:0][ELEM_W-1:0] regs_q;
  logic [ELEM_W-1:0] a, b, res;

  assign a         = regs_q[va_i];
  assign b         = regs_q[vb_i];
  assign lt_o      = $signed(a) < $signed(b);
  assign rd_data_o = regs_q[rd_idx_i];

  always_comb begin
    unique case (op_i)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_LDI:  res = imm_i;
      default: res = a;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   regs_q <= '0;
    else if (we_i) regs_q[vd_i] <= res;
  end

  // inactive lane slice never moves (R2, R3, R9)
  p_lane_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q));
endmodule

// File: rtl/pvu_popcnt.sv
module pvu_popcnt #(
  parameter int W     = 8,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     bits_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CNT_W'(bits_i[i]);
  end
endmodule

// File: rtl/pred_vec_unit.sv
module pred_vec_unit
  import pvu_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int ELEM_W   = 32,
  parameter int NUM_VREG = 8,
  parameter int NUM_PREG = 4,
  localparam int VIDX_W  = $clog2(NUM_VREG),
  localparam int PIDX_W  = $clog2(NUM_PREG),
  localparam int CNT_W   = $clog2(LANES + 1),
  localparam int VEC_W   = LANES * ELEM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [VIDX_W-1:0] vd_i,
  input  logic [VIDX_W-1:0] va_i,
  input  logic [VIDX_W-1:0] vb_i,
  input  logic [PIDX_W-1:0] pd_i,
  input  logic [PIDX_W-1:0] ps_i,
  input  logic              pen_i,
  input  logic              pinv_i,
  input  logic [VEC_W-1:0]  imm_i,
  input  logic [VIDX_W-1:0] rd_vidx_i,
  input  logic [PIDX_W-1:0] rd_pidx_i,
  output logic [VEC_W-1:0]  rd_vdata_o,
  output logic [LANES-1:0]  rd_pdata_o,
  output logic [CNT_W-1:0]  scal_o,
  output logic              scal_valid_o,
  output logic              zero_o
);
  pvu_op_e op;
  logic vec_wr, cmp_wr, cnt_wr;
  logic [NUM_PREG-1:0][LANES-1:0] preg_q;
  logic [LANES-1:0] sel_pred, act, lt;
  logic [CNT_W-1:0] cnt;

  assign op       = pvu_op_e'(op_i);
  assign vec_wr   = valid_i && (op inside {OP_MOV, OP_ADD, OP_SUB, OP_LDI});
  assign cmp_wr   = valid_i && (op == OP_CMPLT);
  assign cnt_wr   = valid_i && (op == OP_POPC);
  assign sel_pred = preg_q[ps_i] ^ {LANES{pinv_i}};
  assign act      = pen_i ? sel_pred : '1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pvu_lane #(.ELEM_W(ELEM_W), .NUM_VREG(NUM_VREG)) lane_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (vec_wr && act[g]),
      .op_i      (op),
      .vd_i      (vd_i),
      .va_i      (va_i),
      .vb_i      (vb_i),
      .imm_i     (imm_i[g*ELEM_W +: ELEM_W]),
      .rd_idx_i  (rd_vidx_i),
      .lt_o      (lt[g]),
      .rd_data_o (rd_vdata_o[g*ELEM_W +: ELEM_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     preg_q <= '0;
    else if (cmp_wr) preg_q[pd_i] <= lt;
  end

  assign rd_pdata_o = preg_q[rd_pidx_i];

  pvu_popcnt #(.W(LANES)) popcnt_i (.bits_i(sel_pred), .cnt_o(cnt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scal_o       <= '0;
      zero_o       <= 1'b0;
      scal_valid_o <= 1'b0;
    end else begin
      scal_valid_o <= cnt_wr;
      if (cnt_wr) begin
        scal_o <= cnt;
        zero_o <= (sel_pred == '0);
      end
    end
  end

  p_pred_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_wr |=> $stable(preg_q));
  p_cnt_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> scal_valid_o);
  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scal_valid_o |-> scal_o <= CNT_W'(LANES));
  p_zero_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scal_valid_o |-> (zero_o == (scal_o == '0)));
endmodule

// File: tb/pred_vec_unit_tb_top.sv
module pred_vec_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [2:0] op_i = '0, vd_i = '0, va_i = '0, vb_i = '0, rd_vidx_i = '0;
  logic [1:0] pd_i = '0, ps_i = '0, rd_pidx_i = '0;
  logic pen_i = 1'b0, pinv_i = 1'b0;
  logic [255:0] imm_i = '0, rd_vdata_o;
  logic [7:0] rd_pdata_o;
  logic [3:0] scal_o;
  logic scal_valid_o, zero_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [255:0] mv [8];
  logic [7:0]   mp [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_vec_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .vd_i(vd_i), .va_i(va_i), .vb_i(vb_i), .pd_i(pd_i), .ps_i(ps_i),
    .pen_i(pen_i), .pinv_i(pinv_i), .imm_i(imm_i),
    .rd_vidx_i(rd_vidx_i), .rd_pidx_i(rd_pidx_i),
    .rd_vdata_o(rd_vdata_o), .rd_pdata_o(rd_pdata_o),
    .scal_o(scal_o), .scal_valid_o(scal_valid_o), .zero_o(zero_o));

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rand_elem();
    case ($urandom % 5)
      0: return 32'($signed($urandom % 9) - 4);
      1: return 32'h8000_0000;
      2: return 32'h7fff_ffff;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [255:0] rand_vec();
    logic [255:0] v;
    for (int l = 0; l < 8; l++) v[l*32 +: 32] = rand_elem();
    return v;
  endfunction

  // one instruction; expected values come from the model, then the model is updated
  task automatic issue(input logic [2:0] op, input int vd, va, vb, pd, ps,
                       input logic pen, pinv, input logic [255:0] imm, input string tag,
                       input logic en = 1'b1);
    logic [7:0] sel, act, lt;
    logic [255:0] nv;
    logic [31:0] a, b, r;
    int cnt;
    sel = mp[ps] ^ {8{pinv}};
    act = pen ? sel : 8'hFF;
    nv  = mv[vd];
    cnt = $countones(sel);
    for (int l = 0; l < 8; l++) begin
      a = mv[va][l*32 +: 32];
      b = mv[vb][l*32 +: 32];
      lt[l] = $signed(a) < $signed(b);
      case (op)
        3'd3: r = a + b;
        3'd4: r = a - b;
        3'd5: r = imm[l*32 +: 32];
        default: r = a;
      endcase
      if (act[l]) nv[l*32 +: 32] = r;
    end
    @(negedge clk);
    valid_i = en; op_i = op; vd_i = 3'(vd); va_i = 3'(va); vb_i = 3'(vb);
    pd_i = 2'(pd); ps_i = 2'(ps); pen_i = pen; pinv_i = pinv; imm_i = imm;
    @(posedge clk);
    #1 valid_i = 1'b0; rd_vidx_i = 3'(vd); rd_pidx_i = 2'(pd);
    #1;
    if (!en || op == 3'd0 || op == 3'd7) begin
      check(rd_vdata_o == mv[vd], tag, rd_vdata_o, mv[vd]);
      check(rd_pdata_o == mp[pd], tag, 256'(rd_pdata_o), 256'(mp[pd]));
    end else if (op == 3'd1) begin
      check(rd_pdata_o == lt, tag, 256'(rd_pdata_o), 256'(lt));
      mp[pd] = lt;
    end else if (op == 3'd6) begin
      check(scal_valid_o && scal_o == 4'(cnt), tag, 256'({scal_valid_o, scal_o}), 256'({1'b1, 4'(cnt)}));
      check(zero_o == (cnt == 0), tag, 256'(zero_o), 256'(cnt == 0));
    end else begin
      check(rd_vdata_o == nv, tag, rd_vdata_o, nv);
      mv[vd] = nv;
    end
  endtask

  initial begin
    void'($urandom(32'h00C0_FFEE));
    for (int i = 0; i < 8; i++) mv[i] = '0;
    for (int i = 0; i < 4; i++) mp[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R8 reset state
    for (int i = 0; i < 8; i++) begin
      rd_vidx_i = 3'(i); rd_pidx_i = 2'(i % 4); #1;
      check(rd_vdata_o == '0, "R8 vreg", rd_vdata_o, '0);
      check(rd_pdata_o == '0, "R8 preg", 256'(rd_pdata_o), '0);
    end
    check(!scal_valid_o && scal_o == '0, "R8 scalar", 256'({scal_valid_o, scal_o}), '0);
    // R6 unpredicated loads fill all registers, predicate ignored
    for (int i = 0; i < 6; i++) issue(3'd5, i, 0, 0, 0, i % 4, 1'b0, 1'b1, rand_vec(), "R6/R7 ldi");
    issue(3'd5, 6, 0, 0, 0, 0, 1'b0, 1'b0, '0, "R6 ldi zero");
    issue(3'd5, 7, 0, 0, 0, 0, 1'b0, 1'b0, {8{32'd1}}, "R6 ldi one");
    // R1/R5 all-one and all-zero predicates
    issue(3'd1, 0, 6, 7, 3, 0, 1'b0, 1'b0, '0, "R1 all-one cmp");
    issue(3'd1, 0, 7, 6, 2, 0, 1'b0, 1'b0, '0, "R1 all-zero cmp");
    issue(3'd1, 0, 6, 6, 1, 0, 1'b0, 1'b0, '0, "R1 equal lanes");
    issue(3'd6, 0, 0, 0, 0, 3, 1'b0, 1'b1, '0, "R5 inverted all-one count");
    issue(3'd6, 0, 0, 0, 0, 3, 1'b0, 1'b0, '0, "R4 full count");
    issue(3'd6, 0, 0, 0, 0, 2, 1'b0, 1'b0, '0, "R5 plain all-zero count");
    // R2/R3 with all-zero predicate: nothing vs everything
    issue(3'd5, 5, 0, 0, 0, 2, 1'b1, 1'b0, rand_vec(), "R2 empty mask");
    issue(3'd5, 5, 0, 0, 0, 2, 1'b1, 1'b1, rand_vec(), "R3 inverted empty mask");
    // R9 idle and reserved
    issue(3'd2, 1, 2, 3, 0, 0, 1'b0, 1'b0, '0, "R9 valid low", 1'b0);
    issue(3'd7, 1, 2, 3, 0, 0, 1'b0, 1'b0, rand_vec(), "R9 reserved op");
    issue(3'd0, 2, 2, 3, 1, 0, 1'b0, 1'b0, rand_vec(), "R9 nop");
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [2:0] op;
      logic pen, pinv;
      string tag;
      op = 3'($urandom % 8);
      pen = 1'($urandom % 4 != 0);
      pinv = 1'($urandom);
      case (op)
        3'd1: tag = "R1 rand cmp";
        3'd6: tag = "R4/R5 rand count";
        3'd0, 3'd7: tag = "R9 rand idle";
        default: tag = !pen ? "R6/R7 rand write" : (pinv ? "R3/R7 rand write" : "R2/R7 rand write");
      endcase
      if (op == 3'd5 && ($urandom % 3 == 0)) begin
        issue(op, $urandom % 8, 0, 0, 0, 0, 1'b0, 1'b0, rand_vec(), "R6 reseed");
      end else begin
        issue(op, $urandom % 8, $urandom % 8, $urandom % 8, $urandom % 4, $urandom % 4,
              pen, pinv, rand_vec(), tag, 1'($urandom % 8 != 0));
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule